// File: doc/BRIEF.md
# Legacy Region Memory Attribute Decoder

This block classifies each memory request by address and sends it to one of two places: system DRAM or the downstream I/O hub. Below 1 MB it handles three kinds of region. The option-ROM and BIOS range is split into segments, and each segment has its own read-enable and write-enable attribute. The two legacy video windows always go to the hub. Just under the top of low memory there is a high management segment, which only management-mode processor requests can open to DRAM. Any other address goes to DRAM when it is below the top of low memory and to the hub when it is above it.

The attributes are stored as nibbles in a bank of byte-wide attribute registers. The top-of-low-memory value is a 16-bit register. All of them are loaded through a byte write port that is addressed by configuration offset. The routing decision is registered, so each result appears one clock after its request. A hit flag tells the caller that the address fell into one of the special regions.

Top module: `lgcy_region_decoder`

## Requirements
- R1: Synchronous active-high reset has these effects. Both outputs read 0 while reset is held. Every attribute nibble is cleared, so every attribute segment routes to the hub. The top-of-low-memory register returns to 0100h.
- R2: A processor read (req_master=0, req_write=0) that lands in an attribute segment sets hit_o=1. It routes to DRAM (dest_o=1) when that segment's read-enable is set and to the hub (dest_o=0) when it is clear.
- R3: A processor write that lands in an attribute segment routes by that segment's write-enable alone, with hit_o=1. The read-enable bit has no effect on it.
- R4: A bus-master request (req_master=1) to an attribute segment goes to DRAM only when both enables are set. Otherwise it goes to the hub. This holds for reads and for writes.
- R5: In each nibble, bit 0 is read-enable and bit 1 is write-enable. The upper nibble of the byte at offset 90h covers the whole 64 KB at 0F0000h–0FFFFFh. Segment k is the 16 KB at 0C0000h + k·4000h, for k = 0 to 11. The lower nibble of offset 91h+j covers segment 2j, and the upper nibble covers segment 2j+1.
- R6: Nibble bits 2–3 and the lower nibble of offset 90h are reserved. Writing them has no effect on routing.
- R7: The ranges 0A0000h–0AFFFFh and 0B0000h–0B7FFFh give hit_o=1 and dest_o=0, whatever the attributes and the request type.
- R8: The management segment is [TOM·2^20 − 2^20, TOM·2^20). An access there gives hit_o=1. It goes to DRAM only for a processor request with req_smm=1, and to the hub otherwise.
- R9: Any address outside the regions above gives hit_o=0. It goes to DRAM when it is below TOM·2^20 and to the hub otherwise. This includes 0B8000h–0BFFFFh.
- R10: Offset C4h writes TOM bits 7:0 and offset C5h writes TOM bits 15:8. The new value applies from the next request. Writes to offsets that are not in the map change nothing.
- R11: The outputs for a request sampled at one clock edge appear after that edge and hold until the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration byte write strobe |
| cfg_ofs | input | 8 | Configuration byte offset |
| cfg_data | input | 8 | Configuration byte value |
| req_addr | input | 32 | Request memory address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_master | input | 1 | 1 = bus master, 0 = processor |
| req_smm | input | 1 | Processor request in management mode |
| dest_o | output | 1 | 1 = system DRAM, 0 = downstream hub |
| hit_o | output | 1 | Address fell in a video, attribute or management region |

## Verification
The bench builds the block with its default parameters. These are a 32-bit address, twelve 16 KB segments, and a 1 MB unit for both the top-of-memory value and the management segment. With the reset value of 0100h, the management window sits at 0FF00000h–0FFFFFFFh. At that size one bench can reach both edges of the window, the plain range on each side of the boundary, and a top-of-memory move across the 256 MB line. All twelve segments plus the BIOS area can be reached with short configuration writes. The attribute patterns set read-only, write-only, both enables, and reserved-bits-only, so the three routing rules differ from each other on the same addresses.

// File: rtl/lgcy_pkg.sv
`timescale 1ns/1ps
package lgcy_pkg;

    typedef enum logic {
        DEST_HUB  = 1'b0,
        DEST_DRAM = 1'b1
    } dest_e;

    typedef enum logic [1:0] {
        RGN_PLAIN = 2'd0,
        RGN_VIDEO = 2'd1,
        RGN_SEG   = 2'd2,
        RGN_MGMT  = 2'd3
    } rgn_e;

    typedef struct packed {
        logic we;
        logic re;
    } attr_t;

    localparam int SEG_LOG2     = 14;
    localparam int GFX_LO       = 32'h000A_0000;
    localparam int GFX_END      = 32'h000B_0000;
    localparam int MONO_LO      = 32'h000B_0000;
    localparam int MONO_END     = 32'h000B_8000;
    localparam int BIOS_LO      = 32'h000F_0000;
    localparam int LEGACY_END   = 32'h0010_0000;
    localparam logic [7:0] NIB_KEEP = 8'h33;

    function automatic attr_t nib_to_attr(input logic [3:0] nib);
        attr_t a;
        a.re = nib[0];
        a.we = nib[1];
        return a;
    endfunction

    function automatic dest_e pick_dest(input logic go_dram);
        return go_dram ? DEST_DRAM : DEST_HUB;
    endfunction

endpackage

// File: rtl/lgcy_attr_bank.sv
`timescale 1ns/1ps
module lgcy_attr_bank
    import lgcy_pkg::*;
#(
    parameter int          NUM_SEG   = 12,
    parameter int          CFG_AW    = 8,
    parameter logic [7:0]  ATTR_BASE = 8'h90,
    parameter logic [7:0]  TOM_OFS   = 8'hC4,
    parameter logic [15:0] TOM_RST   = 16'h0100
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_ofs,
    input  logic [7:0]        cfg_data,
    output attr_t             seg_attr [NUM_SEG],
    output attr_t             bios_attr,
    output logic [15:0]       tom
);
    localparam int NUM_REG = NUM_SEG / 2 + 1;

    logic [7:0] attr_q [NUM_REG];
    logic [7:0] tom_lo_q, tom_hi_q;

    for (genvar i = 0; i < NUM_REG; i++) begin : g_reg
        localparam logic [CFG_AW-1:0] MY_OFS = CFG_AW'(ATTR_BASE) + CFG_AW'(i);
        // the lowest byte only owns its upper nibble
        localparam logic [7:0] KEEP = (i == 0) ? 8'h30 : NIB_KEEP;
        always_ff @(posedge clk) begin
            if (rst)
                attr_q[i] <= 8'h00;
            else if (cfg_we && cfg_ofs == MY_OFS)
                attr_q[i] <= cfg_data & KEEP;
        end
    end

    for (genvar k = 0; k < NUM_SEG; k++) begin : g_seg
        localparam int RI = 1 + k / 2;
        if (k % 2 == 0) begin : g_lo
            assign seg_attr[k] = nib_to_attr(attr_q[RI][3:0]);
        end else begin : g_hi
            assign seg_attr[k] = nib_to_attr(attr_q[RI][7:4]);
        end
    end

    assign bios_attr = nib_to_attr(attr_q[0][7:4]);

    always_ff @(posedge clk) begin
        if (rst) begin
            tom_lo_q <= TOM_RST[7:0];
            tom_hi_q <= TOM_RST[15:8];
        end else if (cfg_we) begin
            if (cfg_ofs == CFG_AW'(TOM_OFS))
                tom_lo_q <= cfg_data;
            if (cfg_ofs == CFG_AW'(TOM_OFS) + CFG_AW'(1))
                tom_hi_q <= cfg_data;
        end
    end

    assign tom = {tom_hi_q, tom_lo_q};

endmodule

// File: rtl/lgcy_addr_classify.sv
`timescale 1ns/1ps
module lgcy_addr_classify
    import lgcy_pkg::*;
#(
    parameter int ADDR_W        = 32,
    parameter int NUM_SEG       = 12,
    parameter int TOM_UNIT_LOG2 = 20,
    parameter int MGMT_LOG2     = 20
) (
    input  logic [ADDR_W-1:0]          addr,
    input  logic [15:0]                tom,
    output rgn_e                       rgn,
    output logic                       is_bios,
    output logic [$clog2(NUM_SEG)-1:0] seg_idx,
    output logic                       below_tom
);
    localparam int BW       = 16 + TOM_UNIT_LOG2;
    localparam int CW       = ((BW > ADDR_W) ? BW : ADDR_W) + 1;
    localparam int SIW      = $clog2(NUM_SEG);
    localparam int SEG_BASE = BIOS_LO - (NUM_SEG << SEG_LOG2);

    logic [CW-1:0] a_ext, bound, mgmt_sz, seg_off;
    logic          in_low, in_video, in_seg, in_mgmt;

    always_comb begin
        a_ext    = CW'(addr);
        bound    = CW'(tom) << TOM_UNIT_LOG2;
        mgmt_sz  = CW'(1) << MGMT_LOG2;
        in_low   = a_ext < CW'(LEGACY_END);
        in_video = (a_ext >= CW'(GFX_LO)  && a_ext < CW'(GFX_END)) ||
                   (a_ext >= CW'(MONO_LO) && a_ext < CW'(MONO_END));
        in_seg   = a_ext >= CW'(SEG_BASE);
        is_bios  = in_low && a_ext >= CW'(BIOS_LO);
        seg_off  = a_ext - CW'(SEG_BASE);
        seg_idx  = SIW'(seg_off >> SEG_LOG2);
        in_mgmt  = (bound >= mgmt_sz) && (a_ext >= bound - mgmt_sz) && (a_ext < bound);
        below_tom = a_ext < bound;

        if (in_low && in_video)     rgn = RGN_VIDEO;
        else if (in_low && in_seg)  rgn = RGN_SEG;
        else if (in_low)            rgn = RGN_PLAIN;
        else if (in_mgmt)           rgn = RGN_MGMT;
        else                        rgn = RGN_PLAIN;
    end

endmodule

// File: rtl/lgcy_route.sv
`timescale 1ns/1ps
module lgcy_route
    import lgcy_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  rgn_e  rgn,
    input  attr_t attr,
    input  logic  below_tom,
    input  logic  is_wr,
    input  logic  is_mst,
    input  logic  is_smm,
    output dest_e dest_q,
    output logic  hit_q
);
    dest_e dest_d;
    logic  hit_d;

    always_comb begin
        hit_d  = 1'b1;
        dest_d = DEST_HUB;
        unique case (rgn)
            RGN_VIDEO: dest_d = DEST_HUB;
            RGN_SEG: begin
                if (is_mst)      dest_d = pick_dest(attr.re && attr.we);
                else if (is_wr)  dest_d = pick_dest(attr.we);
                else             dest_d = pick_dest(attr.re);
            end
            RGN_MGMT:  dest_d = pick_dest(is_smm && !is_mst);
            default: begin
                hit_d  = 1'b0;
                dest_d = pick_dest(below_tom);
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dest_q <= DEST_HUB;
            hit_q  <= 1'b0;
        end else begin
            dest_q <= dest_d;
            hit_q  <= hit_d;
        end
    end

endmodule

// File: rtl/lgcy_region_decoder.sv
`timescale 1ns/1ps
module lgcy_region_decoder
    import lgcy_pkg::*;
#(
    parameter int          ADDR_W        = 32,
    parameter int          NUM_SEG       = 12,
    parameter int          TOM_UNIT_LOG2 = 20,
    parameter int          MGMT_LOG2     = 20,
    parameter int          CFG_AW        = 8,
    parameter logic [7:0]  ATTR_BASE     = 8'h90,
    parameter logic [7:0]  TOM_OFS       = 8'hC4,
    parameter logic [15:0] TOM_RST       = 16'h0100
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_ofs,
    input  logic [7:0]        cfg_data,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    input  logic              req_master,
    input  logic              req_smm,
    output logic              dest_o,
    output logic              hit_o
);
    localparam int SIW = $clog2(NUM_SEG);

    attr_t          seg_attr [NUM_SEG];
    attr_t          bios_attr;
    attr_t          sel_attr;
    logic [15:0]    tom_val;
    rgn_e           rgn;
    logic           is_bios;
    logic [SIW-1:0] seg_idx;
    logic           below_tom;
    dest_e          dest_q;

    lgcy_attr_bank #(
        .NUM_SEG(NUM_SEG), .CFG_AW(CFG_AW), .ATTR_BASE(ATTR_BASE),
        .TOM_OFS(TOM_OFS), .TOM_RST(TOM_RST)
    ) u_bank (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_ofs(cfg_ofs),
        .cfg_data(cfg_data), .seg_attr(seg_attr), .bios_attr(bios_attr),
        .tom(tom_val)
    );

    lgcy_addr_classify #(
        .ADDR_W(ADDR_W), .NUM_SEG(NUM_SEG),
        .TOM_UNIT_LOG2(TOM_UNIT_LOG2), .MGMT_LOG2(MGMT_LOG2)
    ) u_cls (
        .addr(req_addr), .tom(tom_val), .rgn(rgn), .is_bios(is_bios),
        .seg_idx(seg_idx), .below_tom(below_tom)
    );

    always_comb begin
        sel_attr = '0;
        if (is_bios)
            sel_attr = bios_attr;
        else if (int'(seg_idx) < NUM_SEG)
            sel_attr = seg_attr[seg_idx];
    end

    lgcy_route u_route (
        .clk(clk), .rst(rst), .rgn(rgn), .attr(sel_attr),
        .below_tom(below_tom), .is_wr(req_write), .is_mst(req_master),
        .is_smm(req_smm), .dest_q(dest_q), .hit_q(hit_o)
    );

    assign dest_o = dest_q;

endmodule

// File: rtl/lgcy_region_decoder_chk.sv
`timescale 1ns/1ps
module lgcy_region_decoder_chk
    import lgcy_pkg::*;
#(
    parameter int         ADDR_W        = 32,
    parameter int         TOM_UNIT_LOG2 = 20,
    parameter int         MGMT_LOG2     = 20,
    parameter int         CFG_AW        = 8,
    parameter logic [7:0] TOM_OFS       = 8'hC4
) (
    input logic              clk,
    input logic              rst,
    input logic              cfg_we,
    input logic [CFG_AW-1:0] cfg_ofs,
    input logic [7:0]        cfg_data,
    input logic [ADDR_W-1:0] req_addr,
    input logic              req_write,
    input logic              req_master,
    input logic              req_smm,
    input logic              dest_o,
    input logic              hit_o,
    input rgn_e              rgn,
    input attr_t             sel_attr,
    input logic [15:0]       tom_val
);
    localparam int CW = 16 + TOM_UNIT_LOG2 + ADDR_W;

    logic [CW-1:0] a_w, top_w, win_lo;
    logic          chk_video, chk_mgmt, chk_below;

    always_comb begin
        a_w       = CW'(req_addr);
        top_w     = CW'(tom_val) << TOM_UNIT_LOG2;
        win_lo    = top_w - (CW'(1) << MGMT_LOG2);
        chk_video = (a_w >= CW'(GFX_LO)) && (a_w < CW'(MONO_END));
        chk_mgmt  = (top_w >= (CW'(1) << MGMT_LOG2)) && (a_w >= win_lo) &&
                    (a_w < top_w) && (a_w >= CW'(LEGACY_END));
        chk_below = a_w < top_w;
    end

    assert_video_hub_R7: assert property (@(posedge clk) disable iff (rst)
        $past(!rst) && $past(chk_video) |-> hit_o && !dest_o);

    assert_mgmt_smm_only_R8: assert property (@(posedge clk) disable iff (rst)
        $past(!rst) && $past(chk_mgmt && !(req_smm && !req_master)) |-> hit_o && !dest_o);

    assert_master_both_bits_R4: assert property (@(posedge clk) disable iff (rst)
        $past(!rst) && $past(req_master && rgn == RGN_SEG && !(sel_attr.re && sel_attr.we))
        |-> !dest_o);

    assert_cpu_write_we_R3: assert property (@(posedge clk) disable iff (rst)
        $past(!rst) && $past(!req_master && req_write && rgn == RGN_SEG)
        |-> hit_o && dest_o == $past(sel_attr.we));

    assert_plain_vs_tom_R9: assert property (@(posedge clk) disable iff (rst)
        $past(!rst) && !hit_o |-> dest_o == $past(chk_below));

    assert_tom_low_write_R10: assert property (@(posedge clk) disable iff (rst)
        cfg_we && cfg_ofs == CFG_AW'(TOM_OFS) |=> tom_val[7:0] == $past(cfg_data));

endmodule

bind lgcy_region_decoder lgcy_region_decoder_chk #(
    .ADDR_W(ADDR_W), .TOM_UNIT_LOG2(TOM_UNIT_LOG2), .MGMT_LOG2(MGMT_LOG2),
    .CFG_AW(CFG_AW), .TOM_OFS(TOM_OFS)
) u_chk (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_ofs(cfg_ofs), .cfg_data(cfg_data),
    .req_addr(req_addr), .req_write(req_write), .req_master(req_master),
    .req_smm(req_smm), .dest_o(dest_o), .hit_o(hit_o), .rgn(rgn),
    .sel_attr(sel_attr), .tom_val(tom_val)
);

// File: tb/lgcy_region_decoder_tb.sv
`timescale 1ns/1ps
module lgcy_region_decoder_tb;

    typedef struct packed {
        logic [31:0] a;
        logic        w;
        logic        m;
        logic        s;
        logic        h;
        logic        d;
        logic [3:0]  r;
    } vec_t;

    localparam int NV = 23;
    // fields: address, write, master, smm, expected hit, expected dest (1=DRAM), requirement
    localparam vec_t VECS [NV] = '{
        '{32'h000C0000, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 4'd2},  // R2 seg0 RE set
        '{32'h000C0000, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 4'd3},  // R3 seg0 WE clear
        '{32'h000C4000, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 4'd2},  // R2 seg1 RE clear
        '{32'h000C4000, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 4'd3},  // R3 seg1 WE set
        '{32'h000C0000, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 4'd4},  // R4 master, RE only
        '{32'h000D0000, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 4'd4},  // R4 seg4 both
        '{32'h000D4000, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 4'd4},  // R4 seg5 RE only
        '{32'h000D7FFF, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 4'd5},  // R5 seg5 top byte
        '{32'h000FFFF0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 4'd5},  // R5 BIOS area
        '{32'h000F8000, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 4'd5},  // R5 BIOS master
        '{32'h000EC000, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 4'd6},  // R6 reserved only
        '{32'h000EC000, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 4'd6},  // R6
        '{32'h000A0000, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 4'd7},  // R7 graphics
        '{32'h000B7FFF, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 4'd7},  // R7 mono top
        '{32'h000B8000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 4'd9},  // R9 past mono
        '{32'h0009FFFF, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 4'd9},  // R9 low memory
        '{32'h0FF00000, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 4'd8},  // R8 smm cpu
        '{32'h0FF00000, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 4'd8},  // R8 no smm
        '{32'h0FFFFFFF, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 4'd8},  // R8 master
        '{32'h0FEFFFFF, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 4'd9},  // R9 below window
        '{32'h10000000, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 4'd9},  // R9 at boundary
        '{32'h000C3FFF, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 4'd5},  // R5 seg0 top byte
        '{32'h000E0000, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 4'd5}   // R5 unset seg8
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_ofs = '0;
    logic [7:0]  cfg_data = '0;
    logic [31:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic        req_master = 1'b0;
    logic        req_smm = 1'b0;
    logic        dest_o, hit_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    lgcy_region_decoder u_dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_ofs(cfg_ofs),
        .cfg_data(cfg_data), .req_addr(req_addr), .req_write(req_write),
        .req_master(req_master), .req_smm(req_smm), .dest_o(dest_o), .hit_o(hit_o)
    );

    task automatic chk(input string tag, input logic eh, input logic ed);
        checks++;
        if (hit_o !== eh || dest_o !== ed) begin
            fails++;
            $display("FAIL %s: hit/dest actual %b/%b expected %b/%b", tag, hit_o, dest_o, eh, ed);
        end
    endtask

    task automatic cfg(input logic [7:0] ofs, input logic [7:0] val);
        @(negedge clk);
        cfg_we = 1'b1; cfg_ofs = ofs; cfg_data = val;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic req(input logic [31:0] a, input logic w, input logic m, input logic s);
        @(negedge clk);
        req_addr = a; req_write = w; req_master = m; req_smm = s;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 outputs in reset", 1'b0, 1'b0);
        rst = 1'b0;
        // R1: attributes cleared, TOM at 0100h
        req(32'h000C0000, 1'b0, 1'b0, 1'b0); chk("R1 seg0 read after reset", 1'b1, 1'b0);
        req(32'h000FFFF0, 1'b1, 1'b0, 1'b0); chk("R1 BIOS write after reset", 1'b1, 1'b0);
        req(32'h0FF00000, 1'b0, 1'b0, 1'b1); chk("R1 TOM reset window", 1'b1, 1'b1);

        cfg(8'h90, 8'h3F);
        cfg(8'h91, 8'h21);
        cfg(8'h93, 8'h13);
        cfg(8'h96, 8'hCC);
        for (int i = 0; i < NV; i++) begin
            req(VECS[i].a, VECS[i].w, VECS[i].m, VECS[i].s);
            chk($sformatf("R%0d vector %0d", VECS[i].r, i), VECS[i].h, VECS[i].d);
        end

        // R10: TOM byte writes and an unmapped offset
        cfg(8'hC5, 8'h02);
        req(32'h10000000, 1'b0, 1'b0, 1'b0); chk("R10 high byte raises boundary", 1'b0, 1'b1);
        req(32'h1FF00000, 1'b0, 1'b0, 1'b1); chk("R10 moved window", 1'b1, 1'b1);
        cfg(8'hC4, 8'h80);
        req(32'h27F00000, 1'b0, 1'b0, 1'b1); chk("R10 low byte", 1'b1, 1'b1);
        req(32'h1FF00000, 1'b0, 1'b0, 1'b1); chk("R10 old window now plain", 1'b0, 1'b1);
        cfg(8'h97, 8'hFF);
        req(32'h000E8000, 1'b0, 1'b0, 1'b0); chk("R10 unmapped offset ignored", 1'b1, 1'b0);
        cfg(8'h90, 8'h0F);
        req(32'h000F0000, 1'b0, 1'b0, 1'b0); chk("R6 reserved lower nibble", 1'b1, 1'b0);

        // R11: one-cycle latency, held between edges
        @(negedge clk);
        req_addr = 32'h000C4000; req_write = 1'b1; req_master = 1'b0; req_smm = 1'b0;
        @(negedge clk);
        chk("R11 first request", 1'b1, 1'b1);
        req_addr = 32'h000A0000;
        #1 chk("R11 held before edge", 1'b1, 1'b1);
        @(negedge clk);
        chk("R11 second request", 1'b1, 1'b0);

        // R1: reset again clears attributes
        @(negedge clk); rst = 1'b1;
        @(negedge clk); @(negedge clk);
        chk("R1 outputs in second reset", 1'b0, 1'b0);
        rst = 1'b0;
        req(32'h000C4000, 1'b1, 1'b0, 1'b0); chk("R1 attributes cleared", 1'b1, 1'b0);

        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule